// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block keeps the program counter of a simple in-order core. It takes one instruction word per accepted cycle, along with the two source operand values the register file has already read. It resolves conditional and unconditional branches and loads the counter with either the sequential address or a PC-relative target. It also evaluates compare instructions and returns a single-bit truth value that the core writes back to a register.

A single comparator supports six conditions: equality, inequality, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. Branches and compares share it. Compares come in two forms. The register form compares the two operands. The immediate form replaces the second operand with a 16-bit field from the instruction word.

A branch whose displacement is not a multiple of four raises an error strobe. In that case the counter keeps its value. Every result appears on the outputs after the clock edge that accepts the instruction.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is asserted, and just after it is released, the PC equals the RESET_PC parameter (default 0x00001000), and cmp_we, cmp_value, br_taken and misalign_err are all zero.
- R2: The opcode sits in instr[5:0] and the 16-bit immediate sits in instr[21:6]. The branch opcodes are: equal 0x26, not-equal 0x1E, signed less 0x16, signed greater-or-equal 0x0E, unsigned less 0x36, unsigned greater-or-equal 0x2E, and unconditional 0x06.
- R3: A valid conditional branch with a false condition sets the PC to PC+4. So does a valid opcode that is neither a branch nor a compare.
- R4: A valid conditional branch with a true condition and an aligned displacement sets the PC to PC+4+sign-extended imm and pulses br_taken for one cycle.
- R5: Signed conditions order 0xFFFFFFFF below 0x7FFFFFFF. Unsigned conditions order 0x7FFFFFFF below 0xFFFFFFFF.
- R6: With an aligned displacement, the unconditional branch always takes its target, whatever the operand values.
- R7: A valid branch of any kind (conditional or not, taken or not) with imm[1:0] not equal to 0 pulses misalign_err, leaves the PC unchanged and keeps br_taken low.
- R8: The register-form compare opcodes are: equal 0x20, not-equal 0x18, signed less 0x10, signed greater-or-equal 0x08, unsigned less 0x30, unsigned greater-or-equal 0x28. Each pulses cmp_we, sets cmp_value to exactly 1 or 0, and sets the PC to PC+4.
- R9: The immediate-form compare opcodes are each register-form opcode plus 1. The second operand is imm, sign-extended for the equal, not-equal and signed conditions and zero-extended for the unsigned ones.
- R10: While in_valid is low, the PC holds, and cmp_we, br_taken and misalign_err stay low.
- R11: Results appear at the clock edge that samples in_valid high, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction accepted this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | First source operand value |
| opnd_b | input | 32 | Second source operand value |
| pc_out | output | 32 | Current program counter |
| cmp_we | output | 1 | Compare result write strobe |
| cmp_value | output | 32 | Compare result, 0 or 1 |
| br_taken | output | 1 | The PC was loaded with a branch target |
| misalign_err | output | 1 | A branch displacement was not a multiple of four |

## Verification
The embedded properties check several rules on every cycle: the PC freezes on an error or while idle, at most one of the three strobes fires, the compare value is always boolean, untaken branches fall through, and the unconditional branch always fires. Only the bench's sweeps can show that each of the six conditions orders the boundary operands correctly in both signedness modes, and that immediates are extended the right way for each compare. The same applies to target arithmetic that carries across the displacement's sign, and to the exact opcode values.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int OPC_W   = 6;
  localparam int IMM_W   = 16;
  localparam int IMM_LSB = 6;
  localparam int N_COND  = 6;

  typedef enum logic [2:0] {
    CND_EQ  = 3'd0,
    CND_NE  = 3'd1,
    CND_LT  = 3'd2,
    CND_GE  = 3'd3,
    CND_LTU = 3'd4,
    CND_GEU = 3'd5
  } cond_e;

  typedef enum logic [1:0] {
    K_OTHER  = 2'd0,
    K_BRANCH = 2'd1,
    K_JUMP   = 2'd2,
    K_CMP    = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e kind;
    cond_e cond;
    logic  use_imm;
  } dec_t;

  // opcode tables indexed by the cond_e value
  localparam logic [OPC_W-1:0] BR_OPC   [N_COND] = '{6'h26, 6'h1E, 6'h16, 6'h0E, 6'h36, 6'h2E};
  localparam logic [OPC_W-1:0] CMPR_OPC [N_COND] = '{6'h20, 6'h18, 6'h10, 6'h08, 6'h30, 6'h28};
  localparam logic [OPC_W-1:0] CMPI_OPC [N_COND] = '{6'h21, 6'h19, 6'h11, 6'h09, 6'h31, 6'h29};
  localparam logic [OPC_W-1:0] JMP_OPC = 6'h06;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import nextpc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  always_comb begin
    dec.kind    = K_OTHER;
    dec.cond    = CND_EQ;
    dec.use_imm = 1'b0;
    if (opc == JMP_OPC) begin
      dec.kind = K_JUMP;
    end
    for (int i = 0; i < N_COND; i++) begin
      if (opc == BR_OPC[i]) begin
        dec.kind = K_BRANCH;
        dec.cond = cond_e'(i[2:0]);
      end
      if (opc == CMPR_OPC[i]) begin
        dec.kind = K_CMP;
        dec.cond = cond_e'(i[2:0]);
      end
      if (opc == CMPI_OPC[i]) begin
        dec.kind    = K_CMP;
        dec.cond    = cond_e'(i[2:0]);
        dec.use_imm = 1'b1;
      end
    end
  end

endmodule

// File: rtl/npc_compare.sv
module npc_compare
  import nextpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cond_e             cond,
  output logic              hit
);

  logic is_eq, is_slt, is_ult;

  assign is_eq  = (a == b);
  assign is_slt = ($signed(a) < $signed(b));
  assign is_ult = (a < b);

  always_comb begin
    unique case (cond)
      CND_EQ:  hit = is_eq;
      CND_NE:  hit = !is_eq;
      CND_LT:  hit = is_slt;
      CND_GE:  hit = !is_slt;
      CND_LTU: hit = is_ult;
      CND_GEU: hit = !is_ult;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg
  import nextpc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_target,
  input  logic [IMM_W-1:0] disp,
  output logic [PC_W-1:0]  pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] pc_q, pc_d, seq_pc, tgt_pc;

  assign seq_pc = pc_q + STEP;
  assign tgt_pc = seq_pc + {{(PC_W-IMM_W){disp[IMM_W-1]}}, disp};

  always_comb begin
    pc_d = pc_q;
    if (en) pc_d = sel_target ? tgt_pc : seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R3: a plain advance adds exactly four
  a_r3_step_four: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel_target) |=> (pc_q == $past(pc_q) + STEP));

  // R10: disabled register holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_q));

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                PC_W     = 32,
  parameter int                INSTR_W  = 32,
  parameter logic [PC_W-1:0]   RESET_PC = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic [PC_W-1:0]    pc_out,
  output logic               cmp_we,
  output logic [DATA_W-1:0]  cmp_value,
  output logic               br_taken,
  output logic               misalign_err
);

  localparam int IMM_MSB = IMM_LSB + IMM_W - 1;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  dec_t             dec;
  logic [DATA_W-1:0] imm_ext, b_eff;
  logic hit, is_br, bad_disp, take;
  logic pc_en;
  logic cmp_we_d, br_taken_d, err_d, cmp_bit_d;
  logic cmp_we_q, br_taken_q, err_q, cmp_bit_q;
  logic unused_reg_fields;

  assign opc = instr[OPC_W-1:0];
  assign imm = instr[IMM_MSB:IMM_LSB];
  assign unused_reg_fields = ^instr[INSTR_W-1:IMM_MSB+1];

  npc_decode u_dec (
    .opc (opc),
    .dec (dec)
  );

  // unsigned conditions zero-extend the immediate, the rest sign-extend it
  assign imm_ext = (dec.cond == CND_LTU || dec.cond == CND_GEU)
                   ? {{(DATA_W-IMM_W){1'b0}}, imm}
                   : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign b_eff   = dec.use_imm ? imm_ext : opnd_b;

  npc_compare #(.DATA_W(DATA_W)) u_cmp (
    .a    (opnd_a),
    .b    (b_eff),
    .cond (dec.cond),
    .hit  (hit)
  );

  assign is_br    = (dec.kind == K_BRANCH) || (dec.kind == K_JUMP);
  assign bad_disp = is_br && (imm[1:0] != 2'b00);
  assign take     = (dec.kind == K_JUMP) || ((dec.kind == K_BRANCH) && hit);
  assign pc_en    = in_valid && !bad_disp;

  npc_pcreg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (pc_en),
    .sel_target (take),
    .disp       (imm),
    .pc         (pc_out)
  );

  // next-state for the result strobes
  always_comb begin
    cmp_we_d   = in_valid && (dec.kind == K_CMP);
    cmp_bit_d  = cmp_we_d && hit;
    br_taken_d = in_valid && take && !bad_disp;
    err_d      = in_valid && bad_disp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_we_q   <= 1'b0;
      cmp_bit_q  <= 1'b0;
      br_taken_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cmp_we_q   <= cmp_we_d;
      cmp_bit_q  <= cmp_bit_d;
      br_taken_q <= br_taken_d;
      err_q      <= err_d;
    end
  end

  assign cmp_we       = cmp_we_q;
  assign cmp_value    = {{(DATA_W-1){1'b0}}, cmp_bit_q};
  assign br_taken     = br_taken_q;
  assign misalign_err = err_q;

  // R7: an error leaves the PC where it was
  a_r7_err_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (pc_out == $past(pc_out)));

  // R7: strobes are mutually exclusive
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_we, br_taken, misalign_err}));

  // R8: compare result is boolean and only present with its strobe
  a_r8_bool_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_value[DATA_W-1:1] == '0) && (cmp_we || cmp_value == '0));

  // R10: idle cycle produces no strobes and no PC move
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!cmp_we && !br_taken && !misalign_err && $stable(pc_out)));

  // R6: aligned unconditional branch always reports taken
  a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == JMP_OPC && imm[1:0] == 2'b00) |=> br_taken);

  // R3: untaken aligned conditional branch falls through
  a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == K_BRANCH && !hit && !bad_disp)
      |=> (!br_taken && pc_out == $past(pc_out) + PC_W'(4)));

endmodule

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;

  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [5:0] B_OP [6] = '{6'h26, 6'h1E, 6'h16, 6'h0E, 6'h36, 6'h2E};
  localparam logic [5:0] R_OP [6] = '{6'h20, 6'h18, 6'h10, 6'h08, 6'h30, 6'h28};
  localparam logic [5:0] JOP = 6'h06;
  localparam logic [31:0] VALS [7] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                                       32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h1122_3344};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr, opnd_a, opnd_b;
  logic [31:0] pc_out, cmp_value;
  logic        cmp_we, br_taken, misalign_err;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_pc;

  always #10 clk = ~clk;

  nextpc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pc_out(pc_out), .cmp_we(cmp_we),
    .cmp_value(cmp_value), .br_taken(br_taken), .misalign_err(misalign_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ref_hit(input int c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) >= $signed(b);
      4: return a < b;
      default: return a >= b;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] imm);
    return {10'h155, imm, op};
  endfunction

  // issue one valid instruction at a negedge, check at the following negedge
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input string ctag);
    logic [5:0]  op;
    logic [15:0] imm;
    logic [31:0] npc, ecv;
    logic ecw, ebt, eer, h;
    string t;
    op = ins[5:0];
    imm = ins[21:6];
    npc = exp_pc + 32'd4;
    ecw = 0; ecv = 0; ebt = 0; eer = 0;
    t = "R3";
    for (int i = 0; i < 6; i++) begin
      if (op == B_OP[i]) begin
        h = ref_hit(i, a, b);
        if (imm[1:0] != 0) begin eer = 1; npc = exp_pc; t = "R7"; end
        else if (h) begin ebt = 1; npc = exp_pc + 32'd4 + {{16{imm[15]}}, imm}; t = "R4"; end
        else t = "R3";
      end
      if (op == R_OP[i]) begin
        ecw = 1; ecv = {31'd0, ref_hit(i, a, b)}; t = "R8";
      end
      if (op == (R_OP[i] | 6'h01)) begin
        ecw = 1; t = "R9";
        ecv = {31'd0, ref_hit(i, a, (i >= 4) ? {16'd0, imm} : {{16{imm[15]}}, imm})};
      end
    end
    if (op == JOP) begin
      t = "R6";
      if (imm[1:0] != 0) begin eer = 1; npc = exp_pc; t = "R7"; end
      else begin ebt = 1; npc = exp_pc + 32'd4 + {{16{imm[15]}}, imm}; end
    end
    in_valid = 1'b1; instr = ins; opnd_a = a; opnd_b = b;
    @(negedge clk);
    t = {ctag, " ", t};
    chk({t, " pc"}, pc_out, npc);
    chk({t, " cmp_we"}, {31'd0, cmp_we}, {31'd0, ecw});
    chk({t, " cmp_value"}, cmp_value, ecv);
    chk({t, " br_taken"}, {31'd0, br_taken}, {31'd0, ebt});
    chk({t, " misalign_err"}, {31'd0, misalign_err}, {31'd0, eer});
    exp_pc = npc;
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0; instr = mk(B_OP[0], 16'h0010); opnd_a = 0; opnd_b = 0;
    @(negedge clk);
    chk({tag, " idle pc"}, pc_out, exp_pc);
    chk({tag, " idle strobes"}, {29'd0, cmp_we, br_taken, misalign_err}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = 0; opnd_a = 0; opnd_b = 0;
    exp_pc = RST_PC;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc_out, RST_PC);
    chk("R1 strobes in reset", {28'd0, cmp_we, br_taken, misalign_err, |cmp_value}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc_out, RST_PC);

    // R11: nothing changes before the sampling edge
    in_valid = 1'b1; instr = mk(R_OP[0], 16'd0); opnd_a = 5; opnd_b = 5;
    @(posedge clk); #1;
    // outputs now reflect; compare with values seen just before the edge via a fresh drive
    @(negedge clk);
    in_valid = 1'b0;
    #1 chk("R11 value after edge", {31'd0, cmp_we}, 32'd1);
    @(posedge clk); #1;
    chk("R11 strobe clears after idle edge", {31'd0, cmp_we}, 32'd0);
    exp_pc = exp_pc + 32'd8;
    @(negedge clk);
    exp_pc = exp_pc - 32'd4;
    chk("R11 pc advanced once", pc_out, exp_pc);

    idle("R10");

    // R2 R5: conditional branches and register compares over boundary operands
    for (int c = 0; c < 6; c++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++) begin
          issue(mk(B_OP[c], (i[0] ? 16'h0010 : 16'hFFE0)), VALS[i], VALS[j], "R2 R5");
          issue(mk(R_OP[c], 16'h0000), VALS[i], VALS[j], "R5");
        end

    idle("R10");

    // R9: immediate compares, both extensions
    for (int c = 0; c < 6; c++)
      for (int i = 0; i < 7; i++)
        foreach (VALS[k]) begin
          if (k < 6)
            issue(mk(R_OP[c] | 6'h01, VALS[k][15:0] ^ {16{k[0]}}), VALS[i], 32'h0, "R9");
        end

    // R4: displacement extremes
    issue(mk(B_OP[0], 16'h7FFC), 32'd3, 32'd3, "R4 max");
    issue(mk(B_OP[0], 16'h8000), 32'd3, 32'd3, "R4 min");

    // R6: unconditional branch with arbitrary operands
    for (int i = 0; i < 7; i++)
      issue(mk(JOP, (i[0] ? 16'h0040 : 16'hFFC0)), VALS[i], VALS[6 - i], "R6");

    // R7: misaligned displacements on every branch kind
    for (int c = 0; c < 6; c++) begin
      issue(mk(B_OP[c], 16'h0001), 32'd1, 32'd2, "R7");
      issue(mk(B_OP[c], 16'hFFFF), 32'd2, 32'd1, "R7");
      issue(mk(B_OP[c], 16'h0002), 32'd7, 32'd7, "R7");
    end
    issue(mk(JOP, 16'h0003), 32'd0, 32'd0, "R7");

    // R3: unrelated opcode just advances
    issue(mk(6'h04, 16'h1234), 32'd9, 32'd1, "R3 other");
    issue(mk(6'h3F, 16'h0001), 32'd9, 32'd1, "R3 other");

    idle("R10");
    idle("R10");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule